// File: doc/BRIEF.md
# SD/MMC Host Interrupt Status and Mask Unit

This block gathers the event signals of an SD/MMC host controller into one 32-bit status word. It keeps a 32-bit mask word beside it and drives a single interrupt request line. Each event source sets its own status bit, and that bit stays set until software acknowledges it. Software acknowledges an event by writing the status word with a zero in that bit position. A one written to a bit leaves that bit as it was, so the usual acknowledge value is the complement of the bits being serviced.

A few bit positions carry live levels instead of latched events: command busy, write protect and card signal state. These show the present state of their inputs whenever the status word is read. They never latch and never raise the interrupt. The mask word uses one to mean disabled. After reset every valid source is masked, so software must open the sources it wants to see.

Software reaches both words through a small register port. A write strobe, a read strobe and a one-bit selector pick either the status word or the mask word. Read data is registered.

Top module: `sdirq_unit`

## Requirements
- R1: After reset the status word reads 0x00000000, the mask word reads 0xA37F0505 (every valid source masked) and `irq_o` is low.
- R2: Latched event bits: 0 card removed, 2 card inserted, 8 response end, 10 data end, 16 command index error, 17 CRC failure, 18 stop bit error, 19 data timeout, 20 receive overflow, 21 transmit underrun, 22 command timeout, 24 receive ready, 25 transmit request, 29 illegal function, 31 illegal access. A one on `evt_i` at one of these bits during a clock edge sets that status bit at that edge. The bit stays set after the pulse ends.
- R3: A status write (`reg_sel_i`=0) clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R4: If an event and an acknowledge hit the same status bit in the same cycle, the bit ends set.
- R5: A mask write (`reg_sel_i`=1) stores the written value ANDed with 0xA37F0505. Mask bit 1 disables the source and mask bit 0 enables it.
- R6: `irq_o` is a register equal to the OR of status AND 0xA37F0505 AND NOT mask. It rises on the second clock edge after the event pulse is sampled.
- R7: `irq_o` falls one edge after the edge at which the last pending bit is cleared or masked.
- R8: The live bits read as present input levels: bit 5 `wr_prot_i`, bit 7 `card_sig_i`, bit 30 `cmd_busy_i`. Status writes have no effect on them, and they never raise `irq_o`.
- R9: `evt_i` bits outside the latched set (R2) have no effect: they read as zero in the status word and never raise `irq_o`.
- R10: A read strobe loads `reg_rdata_o` with the selected word at that edge (0 status, 1 mask). `reg_rdata_o` holds its value while no read strobe is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 32 | Event set pulses, one per status bit position |
| cmd_busy_i | input | 1 | Live command busy level |
| wr_prot_i | input | 1 | Live write protect level |
| card_sig_i | input | 1 | Live card signal state level |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_sel_i | input | 1 | Word select: 0 status, 1 mask |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request |

## Verification
Status and mask updates land at the same edge that samples the event or write, so a read strobe on the next cycle shows them. A read's data is due at the negative edge after the edge that sampled the strobe. The interrupt line is one register further on. After a stimulus, the bench therefore checks `irq_o` at the first negative edge, where it must not yet have moved, and again at the second, where it must have moved. A driver queues each expected read word, and a monitor pops and compares it exactly one edge after it sees the read strobe.

// File: rtl/sdirq_pkg.sv
package sdirq_pkg;

    localparam int unsigned REG_W = 32;

    typedef logic [REG_W-1:0] word_t;

    // latched event bit positions
    localparam int unsigned B_CARD_OUT   = 0;
    localparam int unsigned B_CARD_IN    = 2;
    localparam int unsigned B_RESP_DONE  = 8;
    localparam int unsigned B_DATA_DONE  = 10;
    localparam int unsigned B_IDX_ERR    = 16;
    localparam int unsigned B_CRC_ERR    = 17;
    localparam int unsigned B_STOP_ERR   = 18;
    localparam int unsigned B_DATA_TMO   = 19;
    localparam int unsigned B_RX_OVF     = 20;
    localparam int unsigned B_TX_UNF     = 21;
    localparam int unsigned B_CMD_TMO    = 22;
    localparam int unsigned B_RX_READY   = 24;
    localparam int unsigned B_TX_WANT    = 25;
    localparam int unsigned B_BAD_FUNC   = 29;
    localparam int unsigned B_BAD_ACCESS = 31;

    // live level bit positions
    localparam int unsigned B_WR_PROT    = 5;
    localparam int unsigned B_CARD_SIG   = 7;
    localparam int unsigned B_CMD_BUSY   = 30;

    function automatic word_t bit_at(input int unsigned pos);
        return word_t'(1) << pos;
    endfunction

    localparam word_t LATCH_BITS =
        bit_at(B_CARD_OUT)  | bit_at(B_CARD_IN)   | bit_at(B_RESP_DONE) |
        bit_at(B_DATA_DONE) | bit_at(B_IDX_ERR)   | bit_at(B_CRC_ERR)   |
        bit_at(B_STOP_ERR)  | bit_at(B_DATA_TMO)  | bit_at(B_RX_OVF)    |
        bit_at(B_TX_UNF)    | bit_at(B_CMD_TMO)   | bit_at(B_RX_READY)  |
        bit_at(B_TX_WANT)   | bit_at(B_BAD_FUNC)  | bit_at(B_BAD_ACCESS);

    localparam word_t LIVE_BITS =
        bit_at(B_WR_PROT) | bit_at(B_CARD_SIG) | bit_at(B_CMD_BUSY);

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_MASK   = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic cmd_busy;
        logic wr_prot;
        logic card_sig;
    } live_t;

    typedef struct packed {
        logic     wr;
        logic     rd;
        reg_sel_e sel;
        word_t    wdata;
    } bus_req_t;

    // place the live levels at their bit positions
    function automatic word_t live_word(input live_t lv);
        word_t w;
        w = '0;
        w[B_WR_PROT]  = lv.wr_prot;
        w[B_CARD_SIG] = lv.card_sig;
        w[B_CMD_BUSY] = lv.cmd_busy;
        return w;
    endfunction

    // acknowledge rule: written zero clears, written one keeps, event sets
    function automatic word_t ack_merge(input word_t cur, input word_t keep,
                                        input word_t setv);
        return (cur & keep) | setv;
    endfunction

endpackage

// File: rtl/sdirq_status_bank.sv
module sdirq_status_bank
    import sdirq_pkg::*;
#(
    parameter int unsigned W      = REG_W,
    parameter word_t       LATCH  = LATCH_BITS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] ev_i,
    input  logic         ack_wr_i,
    input  logic [W-1:0] ack_data_i,
    output logic [W-1:0] sts_o
);

    logic [W-1:0] sts_q;
    logic [W-1:0] keep_w;
    logic [W-1:0] set_w;

    always_comb begin
        keep_w = ack_wr_i ? ack_data_i : '1;
        set_w  = ev_i & LATCH;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q <= '0;
        end else begin
            sts_q <= ack_merge(sts_q, keep_w, set_w) & LATCH;
        end
    end

    assign sts_o = sts_q;

    generate
        for (genvar b = 0; b < W; b++) begin : g_bit
            if (LATCH[b]) begin : g_latched
                AST_EVENT_SETS: assert property (@(posedge clk) disable iff (rst)
                    ev_i[b] |=> sts_q[b]); // R2
                AST_SET_BEATS_ACK: assert property (@(posedge clk) disable iff (rst)
                    (ev_i[b] && ack_wr_i && !ack_data_i[b]) |=> sts_q[b]); // R4
                AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (rst)
                    (ack_wr_i && !ack_data_i[b] && !ev_i[b]) |=> !sts_q[b]); // R3
                AST_ONE_KEEPS: assert property (@(posedge clk) disable iff (rst)
                    (ack_wr_i && ack_data_i[b] && !ev_i[b]) |=> $stable(sts_q[b])); // R3
            end else begin : g_unused
                AST_NEVER_LATCH: assert property (@(posedge clk) disable iff (rst)
                    ev_i[b] |=> !sts_o[b]); // R9
            end
        end
    endgenerate

endmodule

// File: rtl/sdirq_mask_reg.sv
module sdirq_mask_reg
    import sdirq_pkg::*;
#(
    parameter int unsigned W     = REG_W,
    parameter word_t       VALID = LATCH_BITS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] mask_o
);

    logic [W-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= VALID;
        end else if (wr_i) begin
            mask_q <= wdata_i & VALID;
        end
    end

    assign mask_o = mask_q;

    AST_MASK_STORE: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> (mask_o == ($past(wdata_i) & VALID))); // R5
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> $stable(mask_o)); // R5

endmodule

// File: rtl/sdirq_irq_gen.sv
module sdirq_irq_gen
    import sdirq_pkg::*;
#(
    parameter int unsigned W     = REG_W,
    parameter word_t       VALID = LATCH_BITS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sts_i,
    input  logic [W-1:0] mask_i,
    output logic         irq_o
);

    logic [W-1:0] pend_w;
    logic         irq_q;

    assign pend_w = sts_i & VALID & ~mask_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |pend_w;
        end
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/sdirq_unit.sv
module sdirq_unit
    import sdirq_pkg::*;
#(
    parameter int unsigned W     = REG_W,
    parameter word_t       LATCH = LATCH_BITS,
    parameter word_t       LIVE  = LIVE_BITS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] evt_i,
    input  logic         cmd_busy_i,
    input  logic         wr_prot_i,
    input  logic         card_sig_i,
    input  logic         reg_wr_i,
    input  logic         reg_rd_i,
    input  logic         reg_sel_i,
    input  logic [W-1:0] reg_wdata_i,
    output logic [W-1:0] reg_rdata_o,
    output logic         irq_o
);

    bus_req_t     req;
    live_t        lv;
    logic [W-1:0] sts_w;
    logic [W-1:0] mask_w;
    logic [W-1:0] rdata_q;
    logic [W-1:0] status_view;

    always_comb begin
        req.wr    = reg_wr_i;
        req.rd    = reg_rd_i;
        req.sel   = reg_sel_e'(reg_sel_i);
        req.wdata = reg_wdata_i;
        lv.cmd_busy = cmd_busy_i;
        lv.wr_prot  = wr_prot_i;
        lv.card_sig = card_sig_i;
    end

    assign status_view = sts_w | (live_word(lv) & LIVE);

    sdirq_status_bank #(.W(W), .LATCH(LATCH)) u_status (
        .clk        (clk),
        .rst        (rst),
        .ev_i       (evt_i),
        .ack_wr_i   (req.wr && req.sel == SEL_STATUS),
        .ack_data_i (req.wdata),
        .sts_o      (sts_w)
    );

    sdirq_mask_reg #(.W(W), .VALID(LATCH)) u_mask (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (req.wr && req.sel == SEL_MASK),
        .wdata_i (req.wdata),
        .mask_o  (mask_w)
    );

    sdirq_irq_gen #(.W(W), .VALID(LATCH)) u_irq (
        .clk    (clk),
        .rst    (rst),
        .sts_i  (sts_w),
        .mask_i (mask_w),
        .irq_o  (irq_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (req.rd) begin
            rdata_q <= (req.sel == SEL_MASK) ? mask_w : status_view;
        end
    end

    assign reg_rdata_o = rdata_q;

    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (rst)
        ((sts_w & ~mask_w) != '0) |=> irq_o); // R6
    AST_IRQ_FALL: assert property (@(posedge clk) disable iff (rst)
        ((sts_w & ~mask_w) == '0) |=> !irq_o); // R7
    AST_LIVE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_i && !reg_sel_i) |=> (reg_rdata_o[B_CMD_BUSY] == $past(cmd_busy_i))); // R8
    AST_STATUS_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_i && !reg_sel_i) |=> ((reg_rdata_o & ~(LATCH | LIVE)) == '0)); // R9
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !reg_rd_i |=> $stable(reg_rdata_o)); // R10

endmodule

// File: tb/sdirq_unit_tb.sv
module sdirq_unit_tb;

    localparam logic [31:0] VALID = 32'hA37F0505;
    localparam logic [31:0] LIVE  = 32'h400000A0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] evt = '0;
    logic        busy = 1'b0, wp = 1'b0, csig = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always #2.5 clk = ~clk;

    sdirq_unit u_dut (
        .clk         (clk),
        .rst         (rst),
        .evt_i       (evt),
        .cmd_busy_i  (busy),
        .wr_prot_i   (wp),
        .card_sig_i  (csig),
        .reg_wr_i    (reg_wr),
        .reg_rd_i    (reg_rd),
        .reg_sel_i   (reg_sel),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .irq_o       (irq)
    );

    // monitor: read data is due one edge after the strobe was sampled
    always @(posedge clk) rd_seen <= reg_rd && !rst;

    always @(negedge clk) begin
        if (rd_seen) begin
            logic [31:0] e;
            string       t;
            n_vec++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL scoreboard: read with empty queue, act=%08h exp=none", reg_rdata);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (reg_rdata !== e) begin
                    n_fail++;
                    $display("FAIL %s: rdata act=%08h exp=%08h", t, reg_rdata, e);
                end
            end
        end
    end

    task automatic step(input logic [31:0] ev, input logic wr, input logic rd,
                        input logic sel, input logic [31:0] wd,
                        input logic [31:0] exp, input string tag);
        evt = ev; reg_wr = wr; reg_rd = rd; reg_sel = sel; reg_wdata = wd;
        if (rd) begin
            exp_q.push_back(exp);
            tag_q.push_back(tag);
        end
        @(negedge clk);
        evt = '0; reg_wr = 1'b0; reg_rd = 1'b0;
    endtask

    task automatic rd_word(input logic sel, input logic [31:0] exp, input string tag);
        step('0, 1'b0, 1'b1, sel, '0, exp, tag);
    endtask

    task automatic wr_word(input logic sel, input logic [31:0] wd);
        step('0, 1'b1, 1'b0, sel, wd, '0, "");
    endtask

    task automatic pulse(input logic [31:0] ev);
        step(ev, 1'b0, 1'b0, 1'b0, '0, '0, "");
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        n_vec++;
        if (irq !== exp) begin
            n_fail++;
            $display("FAIL %s: irq act=%0b exp=%0b", tag, irq, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_vec++;
        n_fail++;
        $display("FAIL watchdog: act=running exp=finished");
        finish_run();
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk_irq(1'b0, "R1");
        rd_word(1'b0, 32'h0, "R1");
        rd_word(1'b1, VALID, "R1");

        // R6 masked event raises nothing; status still latches (R2)
        pulse(32'h0000_0100);
        @(negedge clk);
        chk_irq(1'b0, "R5");
        rd_word(1'b0, 32'h0000_0100, "R2");

        // R5 open all sources, only valid bits stored
        wr_word(1'b1, 32'hFFFF_FFFF);
        rd_word(1'b1, VALID, "R5");
        wr_word(1'b1, 32'h0);
        rd_word(1'b1, 32'h0, "R5");
        chk_irq(1'b1, "R6");
        wr_word(1'b0, 32'h0);
        @(negedge clk);
        chk_irq(1'b0, "R7");

        // R6 timing of rise
        pulse(32'h0000_0100);
        chk_irq(1'b0, "R6");
        @(negedge clk);
        chk_irq(1'b1, "R6");
        rd_word(1'b0, 32'h0000_0100, "R2");

        // R3 ones keep
        wr_word(1'b0, 32'hFFFF_FFFF);
        rd_word(1'b0, 32'h0000_0100, "R3");
        chk_irq(1'b1, "R3");

        // R3 zero clears, R7 fall timing
        wr_word(1'b0, ~32'h0000_0100);
        chk_irq(1'b1, "R7");
        @(negedge clk);
        chk_irq(1'b0, "R7");
        rd_word(1'b0, 32'h0, "R3");

        // R4 set beats clear in the same cycle
        pulse(32'h0002_0400);
        step(32'h0002_0000, 1'b1, 1'b0, 1'b0, 32'h0, '0, "");
        rd_word(1'b0, 32'h0002_0000, "R4");

        // R7 masking the last pending bit drops irq
        chk_irq(1'b1, "R6");
        wr_word(1'b1, 32'h0002_0000);
        chk_irq(1'b1, "R7");
        @(negedge clk);
        chk_irq(1'b0, "R7");
        wr_word(1'b0, 32'h0);
        wr_word(1'b1, 32'h0);
        rd_word(1'b0, 32'h0, "R3");

        // R8 live bits
        wp = 1'b1; busy = 1'b1; csig = 1'b0;
        rd_word(1'b0, 32'h4000_0020, "R8");
        wr_word(1'b0, 32'h0);
        csig = 1'b1;
        rd_word(1'b0, 32'h4000_00A0, "R8");
        @(negedge clk);
        chk_irq(1'b0, "R8");
        wp = 1'b0; busy = 1'b0; csig = 1'b0;
        rd_word(1'b0, 32'h0, "R8");

        // R9 bits outside the latched set
        pulse(~VALID);
        @(negedge clk);
        chk_irq(1'b0, "R9");
        rd_word(1'b0, 32'h0, "R9");

        // R2 every latched source at once
        pulse(32'hFFFF_FFFF);
        @(negedge clk);
        chk_irq(1'b1, "R6");
        rd_word(1'b0, VALID, "R2");
        wr_word(1'b1, VALID);
        @(negedge clk);
        chk_irq(1'b0, "R7");

        // R10 read data holds without a strobe
        held = reg_rdata;
        wr_word(1'b0, 32'h0);
        repeat (3) @(negedge clk);
        n_vec++;
        if (reg_rdata !== held) begin
            n_fail++;
            $display("FAIL R10: rdata act=%08h exp=%08h", reg_rdata, held);
        end
        rd_word(1'b0, 32'h0, "R10");
        rd_word(1'b1, VALID, "R10");

        // R1 reset again after activity
        wr_word(1'b1, 32'h0);
        pulse(32'h8000_0000);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk_irq(1'b0, "R1");
        rd_word(1'b1, VALID, "R1");
        rd_word(1'b0, 32'h0, "R1");

        @(negedge clk);
        finish_run();
    end

endmodule